// File: doc/BRIEF.md
# Vertical Accumulating Line Averager

This block shrinks a video field vertically by summing a run of consecutive input lines into each output line. Each column has its own accumulator in a line buffer. A phase accumulator decides which input lines fall into the current window. The window length is the inverse of the scale ratio, so a stronger downscale averages more lines. This gives a low-pass filter that tracks the scale and suppresses vertical aliasing. The fractional phase left over when a window closes carries into the next window, so the window slides continuously over the field and output lines stay phase-correct.

The scale is given as an increment `k` in units of 1/64 line, from 1 to 64. Unity is 64, and `k = 64 * Nout / Nin`. A raw sum of about 64/k lines carries a DC gain of 64/k. The block corrects this gain itself: it multiplies the sum by `k`, shifts right by 6 and saturates to 8 bits. It also reports `k` as the gain factor applied to the current window.

A small state machine runs the window. Its states are:
- `ST_EMPTY`: no pixel of a window has arrived yet.
- `ST_FILL`: the window is open, and the current line does not close it.
- `ST_CLOSE`: the current line is the last line of the window.

Its transitions are:
- `EMPTY->FILL` and `EMPTY->CLOSE`: taken on the first pixel of a window. The path depends on whether phase + k reaches 64.
- `FILL->FILL` and `FILL->CLOSE`: taken at a line end. The path depends on whether phase + 2k reaches 64.
- `CLOSE->EMPTY`: taken at the line end of the closing line. Phase becomes phase + k - 64.

Top module: `vline_avg`

## Requirements
- R1: After reset, `out_valid` is 0 and `gain_out` is 64.
- R2: The increment is latched on the first pixel of each window and is shown on `gain_out` from the next cycle. A `scale_in` of 0 is taken as 1. A value above 64 is taken as 64, so upscaling becomes unity.
- R3: Each input line of an open window adds k to a 6-bit phase. The line on which phase + k reaches 64 or more closes the window, and phase + k - 64 carries into the next window. When k divides 64 and the phase starts at 0, each window holds exactly 64/k lines.
- R4: Output pixels appear only during the closing line of a window. Each one appears one cycle after its input pixel.
- R5: Each output pixel equals min(255, (S * k) >> 6). S is the sum of that column over all lines of the window.
- R6: When k divides 64 and the phase starts at 0, a flat field reproduces its own level.
- R7: Results above 255 saturate to 255.
- R8: A pixel in the same cycle as `line_end` is dropped. Pixels beyond column LINE_W-1 of a line are neither accumulated nor output.
- R9: A `line_end` while no window is open is ignored and does not advance the phase.
- R10: Columns accumulate independently. The accumulator is overwritten, not added to, by the first line of a window.
- R11: No window ever spans more than 64 input lines, so a 14-bit accumulator cannot overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input pixel strobe |
| pix_data | input | 8 | Input pixel value |
| line_end | input | 1 | End of current input line |
| scale_in | input | 7 | Scale increment k, 64 = unity |
| out_valid | output | 1 | Output pixel strobe |
| out_data | output | 8 | Gain-corrected averaged pixel |
| gain_out | output | 7 | Gain factor k of the current window |

## Verification
The assertions hold on every cycle for four properties:
- An output pixel only ever follows an accepted input pixel.
- The gain factor stays within 1 to 64.
- The gain factor only changes right after a pixel.
- No open window lasts more than 64 line ends.

Only the scenarios can show the values produced. These include the window length for each increment, the remainder carried from window to window, the averaged and saturated results, clamping, and the inputs that are dropped or ignored.

// File: rtl/vline_avg_pkg.sv
package vline_avg_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_CLOSE = 2'd2
    } win_state_t;
endpackage

// File: rtl/vline_avg_ctrl.sv
module vline_avg_ctrl
    import vline_avg_pkg::*;
#(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pix_ok,
    input  logic            line_end,
    input  logic [PH_W:0]   scale_in,
    output logic            first_o,
    output logic            close_o,
    output logic            win_open_o,
    output logic [PH_W:0]   inc_cur_o,
    output logic [PH_W:0]   inc_q_o
);
    localparam int SUM_W = PH_W + 2;
    localparam int UNITY_I = 1 << PH_W;
    localparam logic [PH_W:0]    UNITY   = UNITY_I[PH_W:0];
    localparam logic [SUM_W-1:0] UNITY_W = UNITY_I[SUM_W-1:0];
    localparam logic [PH_W:0]    ONE     = {{PH_W{1'b0}}, 1'b1};

    win_state_t       state_q, state_d;
    logic [PH_W-1:0]  phase_q, phase_d;
    logic [PH_W:0]    inc_q, inc_d, scale_eff;
    logic             first_q, first_d;
    logic [SUM_W-1:0] sum_one, sum_two, sum_new;

    always_comb begin
        if (scale_in == '0)        scale_eff = ONE;
        else if (scale_in > UNITY) scale_eff = UNITY;
        else                       scale_eff = scale_in;
    end

    assign sum_one = {2'b00, phase_q} + {1'b0, inc_q};
    assign sum_two = {2'b00, phase_q} + {inc_q, 1'b0};
    assign sum_new = {2'b00, phase_q} + {1'b0, scale_eff};

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        inc_d   = inc_q;
        first_d = first_q;
        unique case (state_q)
            ST_EMPTY: if (pix_ok) begin
                inc_d   = scale_eff;
                first_d = 1'b1;
                state_d = (sum_new >= UNITY_W) ? ST_CLOSE : ST_FILL;
            end
            ST_FILL: if (line_end) begin
                phase_d = sum_one[PH_W-1:0];
                first_d = 1'b0;
                state_d = (sum_two >= UNITY_W) ? ST_CLOSE : ST_FILL;
            end
            ST_CLOSE: if (line_end) begin
                phase_d = sum_one[PH_W-1:0];
                first_d = 1'b0;
                state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            phase_q <= '0;
            inc_q   <= UNITY;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            inc_q   <= inc_d;
            first_q <= first_d;
        end
    end

    always_comb begin
        first_o   = first_q;
        close_o   = 1'b0;
        inc_cur_o = inc_q;
        unique case (state_q)
            ST_EMPTY: begin
                first_o   = 1'b1;
                close_o   = (sum_new >= UNITY_W);
                inc_cur_o = scale_eff;
            end
            ST_FILL:  close_o = 1'b0;
            ST_CLOSE: close_o = 1'b1;
            default:  close_o = 1'b0;
        endcase
    end

    assign win_open_o = (state_q != ST_EMPTY);
    assign inc_q_o    = inc_q;
endmodule

// File: rtl/vline_avg_linebuf.sv
module vline_avg_linebuf #(
    parameter int PIX_W  = 8,
    parameter int LINE_W = 16,
    parameter int ACC_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ok,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             line_end,
    input  logic             first,
    output logic [ACC_W-1:0] sum_o,
    output logic             in_range_o
);
    localparam int COL_W = $clog2(LINE_W + 1);
    localparam int IDX_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam logic [COL_W-1:0] LAST = LINE_W[COL_W-1:0];

    logic [ACC_W-1:0] acc_q [LINE_W];
    logic [COL_W-1:0] col_q;
    logic [ACC_W-1:0] rd_val, pix_ext;
    logic             wr_en;

    assign in_range_o = (col_q < LAST);
    assign wr_en      = pix_ok && in_range_o;
    assign rd_val     = acc_q[col_q[IDX_W-1:0]];
    assign pix_ext    = {{(ACC_W-PIX_W){1'b0}}, pix_data};
    assign sum_o      = first ? pix_ext : (rd_val + pix_ext);

    always_ff @(posedge clk) begin
        if (!rst_n)        col_q <= '0;
        else if (line_end) col_q <= '0;
        else if (wr_en)    col_q <= col_q + 1'b1;
    end

    for (genvar c = 0; c < LINE_W; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (wr_en && (col_q == COL_W'(c)))
                acc_q[c] <= sum_o;
        end
    end
endmodule

// File: rtl/vline_avg_gain.sv
module vline_avg_gain #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 14,
    parameter int PH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] sum,
    input  logic [PH_W:0]    inc,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data
);
    localparam int PROD_W = ACC_W + PH_W + 1;
    localparam logic [PROD_W-1:0] PIX_MAX = {{(PROD_W-PIX_W){1'b0}}, {PIX_W{1'b1}}};

    logic [PROD_W-1:0] prod, scaled;
    logic [PIX_W-1:0]  sat;

    assign prod   = {{(PH_W+1){1'b0}}, sum} * {{ACC_W{1'b0}}, inc};
    assign scaled = prod >> PH_W;
    assign sat    = (scaled > PIX_MAX) ? {PIX_W{1'b1}} : scaled[PIX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= en;
            if (en) out_data <= sat;
        end
    end
endmodule

// File: rtl/vline_avg.sv
module vline_avg #(
    parameter int PIX_W  = 8,
    parameter int LINE_W = 16,
    parameter int PH_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             line_end,
    input  logic [PH_W:0]    scale_in,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic [PH_W:0]    gain_out
);
    localparam int ACC_W = PIX_W + PH_W;

    logic             pix_ok, first, close, win_open, in_range;
    logic [PH_W:0]    inc_cur, inc_q;
    logic [ACC_W-1:0] sum;

    // R8: a pixel coinciding with a line end is dropped
    assign pix_ok = pix_valid && !line_end;

    vline_avg_ctrl #(.PH_W(PH_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pix_ok(pix_ok), .line_end(line_end),
        .scale_in(scale_in), .first_o(first), .close_o(close),
        .win_open_o(win_open), .inc_cur_o(inc_cur), .inc_q_o(inc_q)
    );

    vline_avg_linebuf #(.PIX_W(PIX_W), .LINE_W(LINE_W), .ACC_W(ACC_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .pix_ok(pix_ok), .pix_data(pix_data),
        .line_end(line_end), .first(first), .sum_o(sum), .in_range_o(in_range)
    );

    vline_avg_gain #(.PIX_W(PIX_W), .ACC_W(ACC_W), .PH_W(PH_W)) u_gain (
        .clk(clk), .rst_n(rst_n), .en(pix_ok && in_range && close),
        .sum(sum), .inc(inc_cur), .out_valid(out_valid), .out_data(out_data)
    );

    assign gain_out = inc_q;
endmodule

// File: rtl/vline_avg_chk.sv
module vline_avg_chk #(
    parameter int PH_W = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid,
    input logic          line_end,
    input logic          out_valid,
    input logic [PH_W:0] gain_out,
    input logic          win_open
);
    localparam int CNT_W = PH_W + 2;
    localparam int UNITY_I = 1 << PH_W;
    localparam logic [PH_W:0]    UNITY = UNITY_I[PH_W:0];
    localparam logic [CNT_W-1:0] LIMIT = UNITY_I[CNT_W-1:0];

    logic [CNT_W-1:0] lines_in_win;

    always_ff @(posedge clk) begin
        if (!rst_n || !win_open) lines_in_win <= '0;
        else if (line_end)       lines_in_win <= lines_in_win + 1'b1;
    end

    // R4
    out_follows_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid && !line_end));

    // R2
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_out != '0) && (gain_out <= UNITY));

    // R2
    gain_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_out) |-> $past(pix_valid));

    // R11
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lines_in_win <= LIMIT);
endmodule

bind vline_avg vline_avg_chk #(.PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_end(line_end),
    .out_valid(out_valid), .gain_out(gain_out), .win_open(win_open)
);

// File: tb/vline_avg_test.sv
module vline_avg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic       line_end = 1'b0;
    logic [6:0] scale_in = 7'd64;
    logic       out_valid;
    logic [7:0] out_data;
    logic [6:0] gain_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_phase, m_k, m_x;
    bit m_open, m_first;
    int m_sum [16];

    always #10 clk = ~clk;

    vline_avg uut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .line_end(line_end), .scale_in(scale_in), .out_valid(out_valid),
        .out_data(out_data), .gain_out(gain_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampk(input int s);
        if (s == 0) return 1;
        if (s > 64) return 64;
        return s;
    endfunction

    task automatic do_reset(input int scale);
        rst_n = 1'b0; pix_valid = 1'b0; line_end = 1'b0; scale_in = 7'(scale);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_phase = 0; m_open = 1'b0; m_first = 1'b0; m_x = 0; m_k = 64;
    endtask

    // send one pixel and compare the result visible one cycle later
    task automatic pix(input int v, input string req);
        bit cl, ev;
        int s, ed;
        if (!m_open) begin
            m_k = clampk(int'(scale_in)); m_open = 1'b1; m_first = 1'b1;
        end
        cl = (m_phase + m_k) >= 64;
        ev = 1'b0; ed = 0;
        if (m_x < 16) begin
            s = m_first ? v : m_sum[m_x] + v;
            m_sum[m_x] = s;
            ev = cl;
            ed = (s * m_k) >> 6;
            if (ed > 255) ed = 255;
        end
        m_x++;
        pix_valid = 1'b1; pix_data = 8'(v);
        @(negedge clk);
        pix_valid = 1'b0;
        chk(out_valid == ev, {req, " valid"}, int'(out_valid), int'(ev));
        if (ev) chk(int'(out_data) == ed, {req, " data"}, int'(out_data), ed);
        chk(int'(gain_out) == m_k, "R2 gain", int'(gain_out), m_k);
    endtask

    task automatic model_eol();
        if (m_open) begin
            if (m_phase + m_k >= 64) begin
                m_phase = m_phase + m_k - 64; m_open = 1'b0;
            end else m_phase = m_phase + m_k;
            m_first = 1'b0;
        end
        m_x = 0;
    endtask

    task automatic eol(input bit with_pix, input int v);
        line_end = 1'b1; pix_valid = with_pix; pix_data = 8'(v);
        @(negedge clk);
        line_end = 1'b0; pix_valid = 1'b0;
        chk(out_valid == 1'b0, "R8 no output at line end", int'(out_valid), 0);
        model_eol();
    endtask

    task automatic flat_line(input int n, input int v, input string req);
        for (int i = 0; i < n; i++) pix(v, req);
        eol(1'b0, 0);
    endtask

    task automatic t_reset();
        do_reset(64);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(gain_out == 7'd64, "R1 gain_out", int'(gain_out), 64);
    endtask

    task automatic t_unity();
        do_reset(64);
        pix(7, "R4 unity"); pix(130, "R4 unity"); pix(255, "R4 unity");
        eol(1'b0, 0);
        pix(1, "R3 unity next line"); eol(1'b0, 0);
    endtask

    task automatic t_flat();
        do_reset(16);
        for (int l = 0; l < 4; l++) flat_line(5, 100, "R6 flat k16");
        chk(m_open == 1'b0, "R3 window of 4 lines", int'(m_open), 0);
        for (int l = 0; l < 4; l++) flat_line(3, 37, "R6 flat second window");
    endtask

    task automatic t_columns();
        do_reset(32);
        pix(10, "R10 col"); pix(200, "R10 col"); pix(0, "R10 col"); eol(1'b0, 0);
        pix(30, "R5 col"); pix(100, "R5 col"); pix(255, "R5 col"); eol(1'b0, 0);
        pix(4, "R10 fresh window"); pix(8, "R10 fresh window"); eol(1'b0, 0);
        pix(6, "R10 fresh window"); pix(2, "R10 fresh window"); eol(1'b0, 0);
    endtask

    task automatic t_fraction();
        do_reset(24);
        for (int l = 0; l < 10; l++) flat_line(2, 40 + l * 10, "R3 carried phase");
    endtask

    task automatic t_saturate();
        do_reset(40);
        flat_line(2, 250, "R7 sat");
        flat_line(2, 250, "R7 sat");
    endtask

    task automatic t_clamp();
        do_reset(0);
        for (int l = 0; l < 64; l++) flat_line(2, 200, "R2 k0 clamps to 1 R11");
        do_reset(100);
        pix(77, "R2 upscale clamps to unity"); eol(1'b0, 0);
    endtask

    task automatic t_ignore();
        do_reset(32);
        eol(1'b0, 0); eol(1'b0, 0); eol(1'b0, 0);
        pix(10, "R9 blank lines"); pix(20, "R9 blank lines"); eol(1'b0, 0);
        pix(30, "R9 blank lines"); pix(40, "R9 blank lines"); eol(1'b0, 0);
        pix(10, "R8 concurrent"); eol(1'b1, 200);
        pix(10, "R8 concurrent pixel dropped"); eol(1'b0, 0);
        do_reset(64);
        for (int i = 0; i < 18; i++) pix(i * 3, "R8 beyond line width");
        eol(1'b0, 0);
    endtask

    initial begin
        t_reset();
        t_unity();
        t_flat();
        t_columns();
        t_fraction();
        t_saturate();
        t_clamp();
        t_ignore();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule